// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide register interface with a 2-bit address. Addresses 0, 1 and 2 reach the count port of channels 0, 1 and 2. Address 3 is a write-only control port. A control byte names a channel in its top two bits. It then either freezes a snapshot of that channel's running count for reading, or sets the channel's byte order, counting mode and binary/BCD choice.

Counting advances on a shared clock-enable pulse (`tick`). Each channel drives one output bit, with three behaviours: a level that rises at terminal count, a rate generator that pulses low for one tick each period, and a square wave. The reload for an output frequency f is the tick rate divided by f, rounded to the nearest integer; for example, a 1193182 Hz tick with a reload of 1193 gives about 1 kHz.

The bus is a plain strobe interface with no back-pressure. `wr_en` and `rd_en` are one-cycle strobes sampled on the rising clock edge, and `wr_en` wins if both are high. `rdata` is combinational and shows the byte that a read strobe in the current cycle would consume. Every access completes in one cycle.

Top module: `interval_timer3`

## Requirements
- R1: After reset every output bit is low and every channel is idle with count 0. Each channel is set to LSB-then-MSB access, mode 0, binary counting, and its byte pointer is at the LSB.
- R2: A write to address 3 with bits 7:6 = 00, 01 or 10 addresses channel 0, 1 or 2. Bits 7:6 = 11 is ignored by all channels. With bits 5:4 non-zero the write reprograms the channel: access = bits 5:4, mode code = bits 3:1, BCD = bit 0. Reprogramming stops the count and drives the output low for mode 0 and high for modes 2 and 3.
- R3: Access 01 loads the written byte as the LSB with a zero MSB. Access 10 loads it as the MSB with a zero LSB. Access 11 takes the LSB first and the MSB second. A new count takes effect, and counting starts, only on the write that completes the sequence. A control write returns the byte pointer to the LSB.
- R4: A read of address 0 to 2 returns the byte selected by the access setting: the LSB for 01 and the MSB for 10. For 11 it alternates LSB then MSB, sharing one pointer with writes. With no latch held, the read shows the live count. A read of address 3 returns 0.
- R5: A control byte with bits 5:4 = 00 copies the running count into a snapshot that reads return until every programmed byte of it has been read. A latch command given while a snapshot is held is ignored. Reads do not alter the counter.
- R6: Mode 0 drives the output low when the count is loaded and high once N ticks have elapsed. The output then stays high, while the counter keeps wrapping, until the channel is reprogrammed.
- R7: Mode 2 holds the output high, drives it low for exactly the one tick during which the count is 1, then reloads N; the period is N ticks.
- R8: Mode 3 counts down by two per tick and toggles the output at the end of each half. The high half lasts ceil(N/2) ticks and the low half floor(N/2) ticks.
- R9: With BCD set, the counter decrements as four decimal digits: 0000 wraps to 9999, and 0100 steps to 0099.
- R10: A loaded value of 0 stands for 65536 in binary and 10000 in BCD: the first tick yields FFFF or 9999, and in mode 3 the first tick yields FFFE.
- R11: A channel's count and output change only on a cycle with `tick` high, apart from a control write or a completed load.
- R12: Mode codes 6 and 7 act as modes 2 and 3. Codes 1, 4 and 5 act as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable shared by all channels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (ignored when wr_en is high) |
| addr | input | 2 | Register address: 0 to 2 count ports, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port |
| tmr_out | output | 3 | Channel outputs, bit i for channel i |

## Verification
The assertions check, on every cycle, that a channel's output moves only on a tick or a programming event, that a mode-0 output once high stays high until reprogrammed, and that a rate-generator low pulse lasts exactly one tick. They also check that a held snapshot shows a frozen byte while the counter keeps running. Only the bench's scenarios can show the arithmetic: exact counts after N ticks in binary and BCD, the wrap of a zero load, the asymmetric square-wave halves, the byte-order sequencing with its shared pointer, and the rule that a second latch is dropped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CM_TERM,
    CM_RATE,
    CM_SQUARE
  } cmode_e;

  // Mode code from the control byte to the behaviour actually built.
  function automatic cmode_e map_mode(input logic [2:0] code);
    cmode_e m;
    case (code)
      3'd2, 3'd6: m = CM_RATE;
      3'd3, 3'd7: m = CM_SQUARE;
      default:    m = CM_TERM;
    endcase
    return m;
  endfunction

  // One step down, binary or packed decimal, wrapping at zero.
  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v,
                                                 input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    if (!bcd) begin
      r = v - CNT_W'(1);
    end else begin
      borrow = 1'b1;
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[4*d +: 4] == 4'd0) begin
            r[4*d +: 4] = 4'd9;
          end else begin
            r[4*d +: 4] = v[4*d +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_port.sv
module tmr_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              latch_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output cmode_e            mode,
  output logic              bcd,
  output logic              held,
  output logic              commit,
  output logic [CNT_W-1:0]  load_val,
  output logic [DATA_W-1:0] rdata
);
  acc_e              acc_q;
  logic              hi_q;
  logic [DATA_W-1:0] lo_q;
  logic [CNT_W-1:0]  snap_q;
  logic [CNT_W-1:0]  view;
  logic              rd_hi;
  logic              seq_last;

  always_comb begin
    seq_last = (acc_q != ACC_WORD) || hi_q;
    commit   = data_wr && seq_last;
    case (acc_q)
      ACC_HI:   load_val = {wdata, {DATA_W{1'b0}}};
      ACC_WORD: load_val = {wdata, lo_q};
      default:  load_val = {{DATA_W{1'b0}}, wdata};
    endcase
    view  = held ? snap_q : live_cnt;
    rd_hi = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && hi_q);
    rdata = rd_hi ? view[CNT_W-1 -: DATA_W] : view[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= ACC_WORD;
      mode   <= CM_TERM;
      bcd    <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= '0;
      snap_q <= '0;
      held   <= 1'b0;
    end else if (cfg_wr) begin
      acc_q <= acc_e'(wdata[5:4]);
      mode  <= map_mode(wdata[3:1]);
      bcd   <= wdata[0];
      hi_q  <= 1'b0;
      held  <= 1'b0;
    end else begin
      if (latch_wr && !held) begin
        snap_q <= live_cnt;
        held   <= 1'b1;
      end
      if ((data_wr || data_rd) && acc_q == ACC_WORD) hi_q <= !hi_q;
      if (data_wr && acc_q == ACC_WORD && !hi_q) lo_q <= wdata;
      if (data_rd && held && seq_last) held <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic             cfg_term,
  input  logic             commit,
  input  logic [CNT_W-1:0] load_val,
  input  cmode_e           mode,
  input  logic             bcd,
  output logic [CNT_W-1:0] count,
  output logic             out
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] dec1;
  logic [CNT_W-1:0] dec2;
  logic [CNT_W-1:0] even_ld;
  logic             run_q;

  always_comb begin
    dec1    = count_dec(count, bcd);
    dec2    = count_dec(dec1, bcd);
    even_ld = {reload_q[CNT_W-1:1], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      out      <= 1'b0;
    end else if (cfg_wr) begin
      run_q <= 1'b0;
      out   <= !cfg_term;
    end else if (commit) begin
      count    <= load_val;
      reload_q <= load_val;
      run_q    <= 1'b1;
      out      <= (mode != CM_TERM);
    end else if (tick && run_q) begin
      case (mode)
        CM_RATE: begin
          if (count == CNT_W'(1)) begin
            count <= reload_q;
            out   <= 1'b1;
          end else begin
            count <= dec1;
            out   <= (dec1 != CNT_W'(1));
          end
        end
        CM_SQUARE: begin
          if (count == CNT_W'(1) || count == CNT_W'(2)) begin
            out   <= !out;
            count <= out ? even_ld : reload_q;
          end else begin
            count <= dec2;
          end
        end
        default: begin
          count <= dec1;
          if (dec1 == '0) out <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] tmr_out
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = {ADDR_W{1'b1}};

  logic              ctl_sel;
  logic [1:0]        ctl_ch;
  acc_e              ctl_acc;
  logic              cfg_term;
  logic [NUM_CH-1:0] ch_cfg, ch_latch, ch_wr, ch_rd;
  logic [NUM_CH-1:0] ch_held, ch_commit, ch_is_term, ch_is_rate;
  cmode_e            ch_mode  [NUM_CH];
  logic [DATA_W-1:0] ch_rdata [NUM_CH];

  assign ctl_sel  = wr_en && (addr == CTL_ADDR);
  assign ctl_ch   = wdata[DATA_W-1 -: 2];
  assign ctl_acc  = acc_e'(wdata[5:4]);
  assign cfg_term = (map_mode(wdata[3:1]) == CM_TERM);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ld;
    logic             bcd;

    assign ch_cfg[g]     = ctl_sel && (ctl_ch == 2'(g)) && (ctl_acc != ACC_LATCH);
    assign ch_latch[g]   = ctl_sel && (ctl_ch == 2'(g)) && (ctl_acc == ACC_LATCH);
    assign ch_wr[g]      = wr_en && (addr == ADDR_W'(g));
    assign ch_rd[g]      = rd_en && !wr_en && (addr == ADDR_W'(g));
    assign ch_is_term[g] = (ch_mode[g] == CM_TERM);
    assign ch_is_rate[g] = (ch_mode[g] == CM_RATE);

    tmr_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (ch_cfg[g]),
      .latch_wr (ch_latch[g]),
      .data_wr  (ch_wr[g]),
      .data_rd  (ch_rd[g]),
      .wdata    (wdata),
      .live_cnt (cnt),
      .mode     (ch_mode[g]),
      .bcd      (bcd),
      .held     (ch_held[g]),
      .commit   (ch_commit[g]),
      .load_val (ld),
      .rdata    (ch_rdata[g])
    );

    tmr_counter u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cfg_wr   (ch_cfg[g]),
      .cfg_term (cfg_term),
      .commit   (ch_commit[g]),
      .load_val (ld),
      .mode     (ch_mode[g]),
      .bcd      (bcd),
      .count    (cnt),
      .out      (tmr_out[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/interval_timer3_chk.sv
module interval_timer3_chk #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NUM_CH-1:0] tmr_out,
  input logic [NUM_CH-1:0] ch_cfg,
  input logic [NUM_CH-1:0] ch_commit,
  input logic [NUM_CH-1:0] ch_held,
  input logic [NUM_CH-1:0] ch_is_term,
  input logic [NUM_CH-1:0] ch_is_rate
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_is_term[i] && tmr_out[i] && !ch_cfg[i] && !ch_commit[i]) |=> tmr_out[i]); // R6

    AST_RATE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_is_rate[i] && !tmr_out[i] && tick && !ch_cfg[i] && !ch_commit[i]) |=> tmr_out[i]); // R7

    AST_OUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ch_cfg[i] && !ch_commit[i]) |=> $stable(tmr_out[i])); // R11

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_held[i] && !wr_en && !rd_en && addr == ADDR_W'(i))
        |=> (!$stable(addr) || $stable(rdata))); // R5
  end
endmodule

bind interval_timer3 interval_timer3_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (tmr_pkg::DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .rdata      (rdata),
  .tmr_out    (tmr_out),
  .ch_cfg     (ch_cfg),
  .ch_commit  (ch_commit),
  .ch_held    (ch_held),
  .ch_is_term (ch_is_term),
  .ch_is_rate (ch_is_rate)
);

// File: tb/interval_timer3_tb.sv
module interval_timer3_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  wire  [2:0] tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0]  b;
  logic [15:0] v;

  always #5 clk = ~clk;

  interval_timer3 u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tmr_out (tmr_out)
  );

  typedef struct packed {
    logic [7:0]  ctl;
    logic [15:0] load;
    logic [7:0]  nt;
    logic [15:0] cnt;
    logic        o;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h30, 16'd10,   8'd4, 16'd6,    1'b0, 4'd6},   // R6 mid count
    '{8'h70, 16'd3,    8'd3, 16'd0,    1'b1, 4'd6},   // R6 terminal count
    '{8'hB0, 16'd5,    8'd7, 16'hFFFE, 1'b1, 4'd6},   // R6 wraps, stays high
    '{8'h31, 16'h0100, 8'd1, 16'h0099, 1'b0, 4'd9},   // R9 digit borrow
    '{8'h71, 16'h0000, 8'd1, 16'h9999, 1'b0, 4'd9},   // R9 / R10 zero in BCD
    '{8'hB0, 16'h0000, 8'd1, 16'hFFFF, 1'b0, 4'd10},  // R10 zero in binary
    '{8'h34, 16'd5,    8'd3, 16'd2,    1'b1, 4'd7},   // R7 before pulse
    '{8'h74, 16'd5,    8'd5, 16'd5,    1'b1, 4'd7},   // R7 reload
    '{8'hB6, 16'd6,    8'd3, 16'd6,    1'b0, 4'd8},   // R8 first half ends
    '{8'h37, 16'h0011, 8'd1, 16'h0009, 1'b1, 4'd9},   // R9 BCD step of two
    '{8'h7C, 16'd4,    8'd3, 16'd1,    1'b0, 4'd12},  // R12 code 6 as rate
    '{8'hB2, 16'd2,    8'd2, 16'd0,    1'b1, 4'd12}   // R12 code 1 as mode 0
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr  = a;
    rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_word(input int ch, input logic [7:0] ctl, input logic [15:0] val);
    bus_wr(2'd3, ctl);
    bus_wr(2'(ch), val[7:0]);
    bus_wr(2'(ch), val[15:8]);
  endtask

  task automatic read_latched(input int ch, output logic [15:0] val);
    logic [7:0] lo, hi;
    bus_wr(2'd3, {2'(ch), 6'b0});
    bus_rd(2'(ch), lo);
    bus_rd(2'(ch), hi);
    val = {hi, lo};
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "outputs after reset", tmr_out, 3'b000);
    bus_rd(2'd0, b);
    check("R1", "ch0 live LSB", b, 8'h00);
    bus_rd(2'd0, b);
    check("R1", "ch0 live MSB", b, 8'h00);
    bus_rd(2'd3, b);
    check("R4", "control address reads zero", b, 8'h00);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      int ch;
      string rq;
      ch = int'(VEC[k].ctl[7:6]);
      rq = $sformatf("R%0d", VEC[k].req);
      load_word(ch, VEC[k].ctl, VEC[k].load);
      run_ticks(int'(VEC[k].nt));
      check(rq, $sformatf("vec %0d out", k), tmr_out[ch], VEC[k].o);
      read_latched(ch, v);
      check(rq, $sformatf("vec %0d count", k), v, VEC[k].cnt);
    end

    // R2 channel select 11 is ignored
    load_word(0, 8'h30, 16'd100);
    run_ticks(1);
    bus_wr(2'd3, 8'hF4);
    bus_wr(2'd3, 8'hC0);
    run_ticks(1);
    check("R2", "ch0 out after select-11 writes", tmr_out[0], 1'b0);
    read_latched(0, v);
    check("R2", "ch0 still counting", v, 16'd98);

    // R3 single-byte access
    bus_wr(2'd3, 8'h10);
    bus_wr(2'd0, 8'h25);
    bus_rd(2'd0, b);
    check("R3", "LSB-only load", b, 8'h25);
    bus_rd(2'd0, b);
    check("R4", "LSB-only read does not advance", b, 8'h25);
    bus_wr(2'd3, 8'h20);
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, b);
    check("R3", "MSB-only load", b, 8'h03);
    run_ticks(1);
    bus_rd(2'd0, b);
    check("R4", "MSB-only live read after tick", b, 8'h02);

    // R3 control write resets the byte pointer
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h22);
    bus_wr(2'd0, 8'h00);
    read_latched(0, v);
    check("R3", "pointer reset by control", v, 16'h0022);

    // R3 load only after MSB; R6 terminal count
    load_word(0, 8'h30, 16'd1);
    run_ticks(1);
    check("R6", "out high at terminal count", tmr_out[0], 1'b1);
    bus_wr(2'd0, 8'h07);
    check("R3", "LSB alone does not reload", tmr_out[0], 1'b1);
    bus_wr(2'd0, 8'h00);
    check("R3", "MSB completes reload", tmr_out[0], 1'b0);
    read_latched(0, v);
    check("R3", "reloaded count", v, 16'd7);

    // R6 output stays high until reprogrammed
    load_word(0, 8'h30, 16'd3);
    run_ticks(3);
    run_ticks(40);
    check("R6", "out still high", tmr_out[0], 1'b1);
    bus_wr(2'd3, 8'h30);
    check("R6", "reprogram drops out", tmr_out[0], 1'b0);

    // R5 latch hold, second latch ignored, reads do not disturb
    load_word(1, 8'h70, 16'd1000);
    run_ticks(10);
    bus_wr(2'd3, 8'h40);
    run_ticks(5);
    bus_wr(2'd3, 8'h40);
    bus_rd(2'd1, b);
    check("R5", "snapshot LSB", b, 8'hDE);
    run_ticks(3);
    bus_rd(2'd1, b);
    check("R5", "snapshot MSB after second latch", b, 8'h03);
    read_latched(1, v);
    check("R5", "fresh latch after release", v, 16'd982);
    bus_rd(2'd1, b);
    check("R4", "live LSB", b, 8'hD6);
    bus_rd(2'd1, b);
    check("R4", "live MSB", b, 8'h03);

    // R11 nothing moves without tick
    load_word(2, 8'hB0, 16'd2);
    repeat (20) @(negedge clk);
    check("R11", "out without tick", tmr_out[2], 1'b0);
    read_latched(2, v);
    check("R11", "count without tick", v, 16'd2);

    // R8 square wave with odd reload: 1,1,0,0,1
    load_word(0, 8'h36, 16'd5);
    for (int t = 0; t < 5; t++) begin
      logic [4:0] exp_sq;
      exp_sq = 5'b10011;
      run_ticks(1);
      check("R8", $sformatf("square tick %0d", t + 1), tmr_out[0], exp_sq[t]);
    end

    // R7 rate generator N=3: 1,0,1,1,0
    load_word(1, 8'h74, 16'd3);
    for (int t = 0; t < 5; t++) begin
      logic [4:0] exp_rt;
      exp_rt = 5'b01101;
      run_ticks(1);
      check("R7", $sformatf("rate tick %0d", t + 1), tmr_out[1], exp_rt[t]);
    end

    // R10 zero load in square mode
    load_word(2, 8'hB6, 16'd0);
    run_ticks(1);
    read_latched(2, v);
    check("R10", "square zero load first step", v, 16'hFFFE);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule